// File: doc/BRIEF.md
# Integrating Loss-of-Frame Timer

This block turns a severely-errored-frame level into a loss-of-frame defect flag. A tick that fires once per 125 us frame period paces it. An out-of-frame counter accumulates the ticks seen while the framer reports errored framing. It does not restart when the errors pause briefly, so errors that come and go still lead to the defect being declared. A second counter measures unbroken error-free time. That interval clears the defect and returns the accumulated count to zero.

Both windows default to 24 ticks, which is 3 ms at any line rate, because only frame ticks pace the block. A loss-of-signal input is treated exactly like the errored-frame level. With it, the defect follows a dead line by the same 3 ms. All pins are plain levels sampled on the clock. There is no data stream, so there is no handshake and no back-pressure.

Top module: `lof_integrator`

## Requirements
- R1: After reset is released, `lof_out` is 0, and both the accumulated out-of-frame count and the in-frame count start from zero.
- R2: Each cycle with `frame_tick`=1 and an errored-frame level (`sef_in`=1 or `los_in`=1) adds one to the out-of-frame count. `lof_out` rises on the clock edge of the tick that brings the count to DECLARE_TICKS (default 24), and not earlier.
- R3: A run of ticks with the errored-frame level low that is shorter than RELEASE_TICKS (default 24) leaves the out-of-frame count unchanged. Later errored ticks continue from the held value.
- R4: RELEASE_TICKS consecutive ticks with the errored-frame level low return the out-of-frame count to zero.
- R5: When `lof_out` is 1, it falls on the edge of the RELEASE_TICKS-th consecutive error-free tick. Any cycle with the errored-frame level high restarts that run from zero.
- R6: `los_in`=1 counts as an errored frame whatever the value of `sef_in`. `lof_out` rises DECLARE_TICKS ticks after loss of signal begins.
- R7: The out-of-frame count changes only on tick cycles. An errored-frame level that is high only between ticks never advances it, but it does restart the in-frame run.
- R8: Both counts saturate. `lof_out` stays 1 during a long errored period and still clears after exactly RELEASE_TICKS error-free ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sef_in | input | 1 | Severely errored frame level from the framer |
| frame_tick | input | 1 | One-cycle pulse once per frame period |
| los_in | input | 1 | Loss of signal; forces errored-frame treatment |
| lof_out | output | 1 | Loss-of-frame defect flag |

## Verification
The bench goes after the integrating behaviour. An errored burst, then a 23-tick clean gap, then a second burst must declare the defect on the 24th errored tick in total. A design that restarts the count on any clean tick would declare late, and one that never resets the count would declare too early after a 24-tick gap. Clearing is probed one tick short of the window and after a single errored tick inside the clean run, which catches an off-by-one or a clear that sums the error-free time instead of requiring it to be unbroken. Errored levels placed only between ticks expose a count that advances outside ticks, and a 100-tick errored stretch exposes a count that wraps instead of saturating.

// File: rtl/lof_timer_pkg.sv
package lof_timer_pkg;

  // bits needed to hold the values 0 .. limit
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  typedef enum logic {
    ST_IN_FRAME  = 1'b0,
    ST_OUT_FRAME = 1'b1
  } lof_state_e;

endpackage

// File: rtl/lof_sat_counter.sv
module lof_sat_counter #(
  parameter int LIMIT = 24,
  parameter int W     = lof_timer_pkg::cnt_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         hit
);

  localparam logic [W-1:0] TOP     = W'(LIMIT);
  localparam logic [W-1:0] PRE_TOP = W'(LIMIT - 1);

  // asserted in the cycle whose edge brings the count onto LIMIT
  assign hit = inc && !clr && (cnt == PRE_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

  assert_clr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_hold_no_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/lof_flag.sv
module lof_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic declare,
  input  logic release_i,
  output logic lof
);
  import lof_timer_pkg::*;

  lof_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IN_FRAME;
    else begin
      case (state_q)
        ST_IN_FRAME:  if (declare)   state_q <= ST_OUT_FRAME;
        ST_OUT_FRAME: if (release_i) state_q <= ST_IN_FRAME;
        default:      state_q <= ST_IN_FRAME;
      endcase
    end
  end

  assign lof = (state_q == ST_OUT_FRAME);

  assert_no_conflict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(declare && release_i));

endmodule

// File: rtl/lof_integrator.sv
module lof_integrator #(
  parameter int DECLARE_TICKS = 24,
  parameter int RELEASE_TICKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sef_in,
  input  logic frame_tick,
  input  logic los_in,
  output logic lof_out
);

  localparam int OOF_W = lof_timer_pkg::cnt_width(DECLARE_TICKS);
  localparam int INF_W = lof_timer_pkg::cnt_width(RELEASE_TICKS);

  logic             errored;
  logic [OOF_W-1:0] oof_cnt;
  logic [INF_W-1:0] inf_cnt;
  logic             oof_hit;
  logic             inf_hit;

  // loss of signal is handled as an errored frame
  assign errored = sef_in || los_in;

  // error-free run: any errored cycle restarts it
  lof_sat_counter #(.LIMIT(RELEASE_TICKS), .W(INF_W)) u_inframe (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (errored),
    .inc   (frame_tick),
    .cnt   (inf_cnt),
    .hit   (inf_hit)
  );

  // integrating out-of-frame timer: held during short gaps
  lof_sat_counter #(.LIMIT(DECLARE_TICKS), .W(OOF_W)) u_outframe (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (inf_hit),
    .inc   (frame_tick && errored),
    .cnt   (oof_cnt),
    .hit   (oof_hit)
  );

  lof_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .declare   (oof_hit),
    .release_i (inf_hit),
    .lof       (lof_out)
  );

  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_out) |-> $past(frame_tick && (sef_in || los_in)));

  assert_fall_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof_out) |-> $past(frame_tick && !sef_in && !los_in));

  assert_lof_full_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lof_out |-> (oof_cnt == OOF_W'(DECLARE_TICKS)));

  assert_no_move_off_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick) |=> $stable(oof_cnt));

  assert_los_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (los_in && frame_tick && oof_cnt != OOF_W'(DECLARE_TICKS))
      |=> (oof_cnt == $past(oof_cnt) + 1'b1));

endmodule

// File: tb/lof_integrator_test.sv
module lof_integrator_test;
  localparam int CLK_PERIOD = 10;
  localparam int DECL = 24;
  localparam int REL  = 24;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sef_in = 1'b0;
  logic frame_tick = 1'b0;
  logic los_in = 1'b0;
  logic lof_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  int  m_oof = 0;
  int  m_run = 0;
  bit  m_lof = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lof_integrator #(.DECLARE_TICKS(DECL), .RELEASE_TICKS(REL)) uut (
    .clk(clk), .rst_n(rst_n), .sef_in(sef_in),
    .frame_tick(frame_tick), .los_in(los_in), .lof_out(lof_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oof = 0; m_run = 0; m_lof = 1'b0;
    end else begin
      bit bad;
      bad = sef_in || los_in;
      if (bad) begin
        m_run = 0;
        if (frame_tick) begin
          if (m_oof < DECL) m_oof = m_oof + 1;
          if (m_oof == DECL) m_lof = 1'b1;
        end
      end else if (frame_tick && m_run < REL) begin
        m_run = m_run + 1;
        if (m_run == REL) begin
          m_oof = 0;
          m_lof = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit actual, input bit expected, input string req);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: lof_out=%0b expected=%0b at cycle %0d", req, actual, expected, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) check(lof_out, m_lof, cur_req);
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // n frame periods; level on the tick cycle and between ticks
  task automatic ticks(input int n, input bit on_tick, input bit between, input bit los);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_tick = 1'b1; sef_in = on_tick; los_in = los;
      @(negedge clk); frame_tick = 1'b0; sef_in = between;
      @(negedge clk);
      @(negedge clk);
    end
    sef_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; sef_in = 1'b0; los_in = 1'b0; frame_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    cur_req = "R1"; check(lof_out, 1'b0, "R1 reset");

    cur_req = "R2";
    ticks(DECL - 1, 1, 1, 0); check(lof_out, 1'b0, "R2 one tick short");
    ticks(1, 1, 1, 0);        check(lof_out, 1'b1, "R2 declare");

    do_reset(); cur_req = "R3";
    ticks(10, 1, 1, 0); ticks(REL - 1, 0, 0, 0);
    ticks(13, 1, 1, 0); check(lof_out, 1'b0, "R3 held count short");
    ticks(1, 1, 1, 0);  check(lof_out, 1'b1, "R3 held count resumes");

    do_reset(); cur_req = "R4";
    ticks(10, 1, 1, 0); ticks(REL, 0, 0, 0);
    ticks(14, 1, 1, 0); check(lof_out, 1'b0, "R4 count reset after gap");
    ticks(10, 1, 1, 0); check(lof_out, 1'b1, "R4 fresh 24");

    cur_req = "R5";
    ticks(REL - 1, 0, 0, 0); check(lof_out, 1'b1, "R5 one tick short of clear");
    ticks(1, 1, 1, 0); ticks(REL - 1, 0, 0, 0);
    check(lof_out, 1'b1, "R5 run restarted by errored tick");
    ticks(1, 0, 0, 0); check(lof_out, 1'b0, "R5 clear");

    do_reset(); cur_req = "R6";
    ticks(DECL - 1, 0, 0, 1); check(lof_out, 1'b0, "R6 loss of signal short");
    ticks(1, 0, 0, 1);        check(lof_out, 1'b1, "R6 loss of signal declare");
    los_in = 1'b0;

    do_reset(); cur_req = "R7";
    ticks(30, 0, 1, 0); check(lof_out, 1'b0, "R7 off-tick errors ignored by timer");
    ticks(DECL, 1, 1, 0);
    ticks(30, 0, 1, 0); check(lof_out, 1'b1, "R7 off-tick errors block clear");

    do_reset(); cur_req = "R8";
    ticks(100, 1, 1, 0);     check(lof_out, 1'b1, "R8 saturated held");
    ticks(REL - 1, 0, 0, 0); check(lof_out, 1'b1, "R8 short of clear");
    ticks(1, 0, 0, 0);       check(lof_out, 1'b0, "R8 clear after saturation");
    ticks(DECL - 1, 1, 1, 0); check(lof_out, 1'b0, "R8 count back at zero");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule